// File: doc/BRIEF.md
# Glitch-Free Rate-Select Clock Prescaler

This block derives the oversampling clock of a serial network controller from a reference oscillator. The oversampling clock runs at eight times the serial bit rate. A host processor stores a 3-bit rate code in a setup register, and each higher code halves the bit rate. The host writes that register with no regard to the prescaler clock. The prescaler divides the reference by a power of two picked by the code. It produces a square-wave divided clock and a one-cycle enable that marks each rising edge of that clock.

A mode input selects how the stored code reaches the divider. In direct mode the divider compares its counter against the stored code at once. A rate change can then cut short the phase in progress and leave a runt pulse. In synchronized mode the code first crosses two flip-flops clocked by the reference. It is accepted only when both stages hold the same value, and it takes effect at the next terminal count of the divider. In this mode every output phase is a whole phase of either the old rate or the new rate.

Top module: `rps_prescaler`

## Requirements
- R1: While reset is asserted the divided clock is low and the stored code is 0. On the first clock edge after release the divided clock rises. With code 0 it then toggles on every edge.
- R2: The stored code loads `rate_sel` only on an edge where `host_wr` is high. Changes of `rate_sel` while `host_wr` is low have no effect on the output rate.
- R3: With code c in force, the high and low phases of `clk_div` each last 2^c reference cycles, so the period is 2^(c+1) cycles. c is the unsigned value of the 3-bit field, from 0 to 7.
- R4: `clk_en` is high for exactly the one reference cycle before each rising edge of `clk_div`, and at no other time.
- R5: In direct mode (`sync_en` = 0), a phase of `clk_div` ends on the first edge at which the counter has reached or passed 2^c - 1 for the code stored at that moment. A switch from code 3 to code 0, written one cycle into a phase, therefore ends that phase after 2 cycles. Every phase that starts after the write lands has the new length.
- R6: In synchronized mode (`sync_en` = 1), the new code passes two reference flip-flops and is captured only when both hold the same value. A phase that starts on an edge at least 4 edges after the edge that stores the code has the new length.
- R7: In synchronized mode the ratio in force changes only on a terminal-count edge. A phase that starts before that point has the old length, so no phase is cut short; with the same code-3-to-0 write as in R5, the current phase still lasts 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code offered by the host |
| sync_en | input | 1 | 1 selects the synchronized path, 0 the direct path |
| host_wr | input | 1 | Write strobe that stores `rate_sel` |
| clk_div | output | 1 | Divided oversampling clock |
| clk_en | output | 1 | One-cycle pulse ahead of each `clk_div` rise |

## Verification
The bench counts reference edges and takes the edge that stores a code as its time origin. Every output toggle is timed from that origin. In synchronized mode, a phase that starts 4 or more edges after the write must show the new length, and any earlier phase must show the old one. This is the synchronizer depth plus the agreement stage plus the wait for terminal count. In direct mode the phase spanning the write is measured against the 2-cycle runt that R5 predicts, and later phases must show the new length. Inputs are driven 1 ns after a rising edge and outputs are read on the falling edge, so each result is sampled half a cycle after the edge that produces it.

// File: rtl/rps_pkg.sv
package rps_pkg;
  // Length of one output phase, in reference cycles, for a rate code
  function automatic int unsigned phase_cycles(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Counter value at which a phase ends
  function automatic int unsigned term_count(input int unsigned code);
    return phase_cycles(code) - 32'd1;
  endfunction
endpackage

// File: rtl/rps_setup_reg.sv
module rps_setup_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/rps_sel_sync.sv
module rps_sel_sync #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] din,
  output logic [SEL_W-1:0] stage1,
  output logic [SEL_W-1:0] stage2,
  output logic             agree,
  output logic [SEL_W-1:0] dout
);
  assign agree = (stage1 == stage2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
      if (agree) dout <= stage2;
    end
  end
endmodule

// File: rtl/rps_divider.sv
module rps_divider #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             tc,
  output logic             clk_out,
  output logic             clk_en
);
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(rps_pkg::term_count(32'(sel)));
  // At or past the limit: a smaller code ends the phase at once
  assign tc     = (cnt >= limit);
  assign clk_en = tc & ~clk_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (tc) begin
      cnt     <= '0;
      clk_out <= ~clk_out;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rps_prescaler.sv
module rps_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             sync_en,
  input  logic             host_wr,
  output logic             clk_div,
  output logic             clk_en
);
  localparam int MAX_CODE = (1 << SEL_W) - 1;
  localparam int CNT_W    = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [SEL_W-1:0] cfg_sel;
  logic [SEL_W-1:0] sync_s1, sync_s2, sync_sel;
  logic             sync_agree;
  logic [SEL_W-1:0] active_sel;
  logic [SEL_W-1:0] sel_now;
  logic [CNT_W-1:0] div_cnt;
  logic             div_tc;

  rps_setup_reg #(.SEL_W(SEL_W)) u_setup (
    .clk(clk_ref), .rst_n(rst_n), .wr(host_wr), .din(rate_sel), .q(cfg_sel)
  );

  rps_sel_sync #(.SEL_W(SEL_W)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .din(cfg_sel),
    .stage1(sync_s1), .stage2(sync_s2), .agree(sync_agree), .dout(sync_sel)
  );

  // Ratio in force: in synchronized mode it moves only at terminal count,
  // in direct mode it shadows the setup register for a clean mode switch
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)       active_sel <= '0;
    else if (!sync_en) active_sel <= cfg_sel;
    else if (div_tc)  active_sel <= sync_sel;
  end

  assign sel_now = sync_en ? active_sel : cfg_sel;

  rps_divider #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .sel(sel_now),
    .cnt(div_cnt), .tc(div_tc), .clk_out(clk_div), .clk_en(clk_en)
  );
endmodule

// File: rtl/rps_prescaler_chk.sv
module rps_prescaler_chk #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 7
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             sync_en,
  input logic             host_wr,
  input logic [SEL_W-1:0] rate_sel,
  input logic [SEL_W-1:0] cfg_sel,
  input logic             sync_agree,
  input logic [SEL_W-1:0] sync_sel,
  input logic [SEL_W-1:0] active_sel,
  input logic [CNT_W-1:0] div_cnt,
  input logic             div_tc,
  input logic             clk_div,
  input logic             clk_en
);
  logic [CNT_W-1:0] active_limit;
  assign active_limit = CNT_W'(rps_pkg::term_count(32'(active_sel)));

  p_cfg_hold_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !host_wr |=> $stable(cfg_sel));

  p_cfg_load_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    host_wr |=> (cfg_sel == $past(rate_sel)));

  p_en_then_rise_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_en |=> clk_div);

  p_en_while_low_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_en |-> !clk_div);

  p_rise_has_en_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(clk_div) |-> $past(clk_en));

  p_capture_on_agree_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(sync_sel) |-> $past(sync_agree));

  p_hold_until_tc_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sync_en && !div_tc) |=> $stable(active_sel));

  p_cnt_in_range_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sync_en && $past(sync_en) && $past(sync_en, 2)) |-> (div_cnt <= active_limit));
endmodule

bind rps_prescaler rps_prescaler_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .sync_en(sync_en), .host_wr(host_wr),
  .rate_sel(rate_sel), .cfg_sel(cfg_sel), .sync_agree(sync_agree),
  .sync_sel(sync_sel), .active_sel(active_sel), .div_cnt(div_cnt),
  .div_tc(div_tc), .clk_div(clk_div), .clk_en(clk_en)
);

// File: tb/tb_rps_prescaler.sv
`timescale 1ns/1ps
module tb_rps_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       sync_en = 1'b0;
  logic       host_wr = 1'b0;
  logic       clk_div, clk_en;

  rps_prescaler #(.SEL_W(3)) dut (
    .clk_ref(clk_ref_w), .rst_n(rst_n), .rate_sel(rate_sel), .sync_en(sync_en),
    .host_wr(host_wr), .clk_div(clk_div), .clk_en(clk_en)
  );
  wire clk_ref_w = clk;

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // Model state of the write in progress
  int wr_edge = -1000;
  int n_old = 1;
  int n_new = 1;
  int straddle_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL all requirements: watchdog expired, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Output monitor on the falling edge
  bit prev_out = 1'b0, prev_en = 1'b0, prev_rst = 1'b0, have_tog = 1'b0;
  int last_tog = 0;
  always @(negedge clk) begin
    if (rst_n && prev_rst) begin
      // R4: enable precedes each rise and nothing else
      if (prev_en) chk(!prev_out && clk_div, "R4 enable not followed by rise", int'(clk_div), 1);
      if (!prev_out && clk_div) chk(prev_en, "R4 rise without enable", int'(prev_en), 1);
    end
    if (rst_n && clk_div != prev_out) begin
      if (have_tog) begin
        int len;
        len = cyc - last_tog;
        if (last_tog <= wr_edge && cyc > wr_edge) straddle_len = len;
        if (sync_en) begin
          // R6 R7 R3: phase length set by its start edge relative to the write
          if (last_tog >= wr_edge + 4)
            chk(len == n_new, "R6 phase after sync latency", len, n_new);
          else
            chk(len == n_old, "R7 phase before terminal hand-over", len, n_old);
        end else if (last_tog > wr_edge) begin
          chk(len == n_new, "R3 direct phase length", len, n_new);
        end
      end
      have_tog = 1'b1;
      last_tog = cyc;
    end
    prev_out = clk_div;
    prev_en  = clk_en;
    prev_rst = rst_n;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic write_code(input int code);
    rate_sel = 3'(code);
    host_wr  = 1'b1;
    wr_edge  = cyc + 1;
    n_old    = n_new;
    n_new    = 1 << code;
    tick();
    host_wr  = 1'b0;
  endtask

  task automatic settle();
    repeat ((n_old + n_new) * 4 + 8) tick();
  endtask

  task automatic wait_toggle();
    bit v0;
    v0 = clk_div;
    tick();
    while (clk_div == v0) tick();
  endtask

  initial begin
    // R1: reset state
    repeat (4) tick();
    @(negedge clk);
    chk(clk_div == 1'b0, "R1 clk_div low in reset", int'(clk_div), 0);
    tick();
    chk(clk_div == 1'b0, "R1 clk_div low in reset", int'(clk_div), 0);
    rst_n = 1'b1;
    tick();
    chk(clk_div == 1'b1, "R1 first edge after release", int'(clk_div), 1);
    tick();
    chk(clk_div == 1'b0, "R1 divide by one", int'(clk_div), 0);
    repeat (8) tick();

    // R3: direct-mode sweep over every code
    for (int i = 0; i < 8; i++) begin
      write_code((i * 5) % 8);
      settle();
    end

    // R2: rate_sel without a strobe is ignored
    write_code(2);
    settle();
    begin
      int togs;
      bit v;
      togs = 0;
      v = clk_div;
      rate_sel = 3'd5;
      for (int k = 0; k < 64; k++) begin
        tick();
        if (clk_div != v) togs++;
        v = clk_div;
      end
      chk(togs == 16, "R2 unstrobed code ignored", togs, 16);
    end

    // R5: direct runt, code 3 to 0 one cycle into a phase
    write_code(3);
    settle();
    wait_toggle();
    write_code(0);
    settle();
    chk(straddle_len == 2, "R5 direct phase cut short", straddle_len, 2);

    // Synchronized mode sweep (R6 R7 via the monitor)
    sync_en = 1'b1;
    repeat (8) tick();
    for (int i = 0; i < 16; i++) begin
      write_code((i * 5) % 8);
      settle();
    end

    // R7: same runt stimulus keeps a full phase
    write_code(3);
    settle();
    wait_toggle();
    write_code(0);
    settle();
    chk(straddle_len == 8, "R7 sync phase kept whole", straddle_len, 8);

    // R6: slow to fast to slow at phase starts
    wait_toggle();
    write_code(7);
    settle();
    wait_toggle();
    write_code(1);
    settle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule